// File: doc/BRIEF.md
# Supply Voltage Detect Controller

This block is the digital side of a two-threshold low-supply monitor in a microcontroller. Two comparator outputs come in: one is high while the supply is under the upper threshold (about 2.2 V) and one is high while it is under the lower threshold (about 1.7 V). Each passes through a two-flop synchroniser. The block keeps two status flags. The upper flag follows the supply. The lower flag latches and stays set until software clears it.

A single 8-bit control register is reachable from the CPU bus through an address, a write strobe, write data and combinational read data. The register also holds two 2-bit clock fields, which are passed through to the clock-switching logic. A mode bit picks the response to a deep dip. In reset mode a registered, active-high system reset is raised. It is held for a parameterised number of clock cycles after the supply recovers, standing in for a stretch of about 65.5 ms. In freeze mode no reset is raised. Instead the clock-run enable drops for as long as the supply stays under the lower threshold. An active-low enable bit turns the whole detector off.

Top module: `supply_guard`

## Requirements
- R1: After the synchronous reset, the register at REG_ADDR reads 0x00, `sys_rst` is 0 and `clk_run` is 1.
- R2: The register bits [1:0] (clock control), [3:2] (clock source), 6 (mode: 1 = freeze, 0 = reset) and 7 (detector off when 1) are read/write. Bits [1:0] drive `clk_ctrl` and bits [3:2] drive `clk_src`.
- R3: Bit 4 (upper flag) reads 1 on the third rising edge after `cmp_upper` goes high. It reads 0 again three edges after `cmp_upper` goes low. Writes to bit 4 have no effect.
- R4: Bit 5 (lower flag) sets when the synchronised `cmp_lower` is high and stays set after `cmp_lower` returns low.
- R5: A write to the register with bit 5 = 0 clears the lower flag. A write with bit 5 = 1 leaves it unchanged.
- R6: A write that clears bit 5 while the synchronised `cmp_lower` is still high has no effect, and the flag stays 1.
- R7: In reset mode, `sys_rst` is 1 while the synchronised `cmp_lower` is high. It stays 1 for exactly STRETCH_CYCLES edges after the synchroniser output falls, then drops. `clk_run` stays 1 throughout.
- R8: A new dip during the stretch reloads the counter, so the full STRETCH_CYCLES stretch restarts from the new recovery.
- R9: In freeze mode, `clk_run` is 0 while the synchronised `cmp_lower` is high and returns to 1 on recovery. `sys_rst` stays 0.
- R10: With bit 7 = 1, both flags read 0, `sys_rst` is 0 and `clk_run` is 1. Setting bit 7 during a stretch ends the reset one edge later.
- R11: Comparator inputs pass two synchroniser flops. A dip first shows on `sys_rst`, `clk_run` or the flags on the third rising edge after the input changes.
- R12: Writes to any address other than REG_ADDR are ignored. Reads at other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_upper | input | 1 | High while the supply is under the upper threshold |
| cmp_lower | input | 1 | High while the supply is under the lower threshold |
| addr | input | 8 | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational on `addr` |
| clk_ctrl | output | 2 | Clock control field to the clock logic |
| clk_src | output | 2 | Clock source field to the clock logic |
| sys_rst | output | 1 | Registered active-high internal system reset |
| clk_run | output | 1 | System clock enable; 0 freezes the core |

## Verification
The bound checker watches four things on every cycle. No reset is issued while in freeze mode or while the detector is off. The clock is never stopped in reset mode. The lower flag sets under a synchronised dip and never drops without a write or a disable. A reset only rises after a dip that came through the synchroniser. Only the bench's scenarios can show the exact stretch length, the restart of the stretch on a second dip, the register read-back, the address decode, and the ignored clear during a dip, because each depends on a specific sequence of inputs.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int REG_W  = 8;
    localparam int N_CH   = 2;

    typedef enum int {
        CH_UPPER = 0,
        CH_LOWER = 1
    } sg_chan_e;

    // Control/status register, MSB first
    typedef struct packed {
        logic       det_off;   // bit 7: 1 turns the detector off
        logic       freeze;    // bit 6: 1 = freeze clock, 0 = reset
        logic       flag_lo;   // bit 5: sticky lower flag
        logic       flag_up;   // bit 4: tracking upper flag
        logic [1:0] clk_src;   // bits 3:2
        logic [1:0] clk_ctrl;  // bits 1:0
    } sg_ctl_t;

    function automatic logic [REG_W-1:0] sg_to_bus(sg_ctl_t c);
        return c;
    endfunction

    function automatic logic sg_clear_req(logic [REG_W-1:0] d);
        return ~d[5];
    endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar c = 0; c < N; c++) begin : g_ch
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[c]};
        end
        assign dout[c] = chain[STAGES-1];
    end
endmodule

// File: rtl/sg_regs.sv
module sg_regs
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic             s_up,
    input  logic             s_lo,
    output sg_ctl_t          ctl
);
    logic det_on;
    assign det_on = ~ctl.det_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_hit) begin
                ctl.clk_ctrl <= wr_data[1:0];
                ctl.clk_src  <= wr_data[3:2];
                ctl.freeze   <= wr_data[6];
                ctl.det_off  <= wr_data[7];
            end
            ctl.flag_up <= det_on & s_up;
            if (!det_on)
                ctl.flag_lo <= 1'b0;
            else if (s_lo)
                ctl.flag_lo <= 1'b1;
            else if (wr_hit && sg_clear_req(wr_data))
                ctl.flag_lo <= 1'b0;
        end
    end
endmodule

// File: rtl/sg_resp.sv
module sg_resp #(
    parameter int STRETCH_CYCLES = 655360
) (
    input  logic clk,
    input  logic rst,
    input  logic det_on,
    input  logic freeze_mode,
    input  logic below,
    output logic sys_rst,
    output logic clk_run
);
    localparam int CW = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

    logic [CW-1:0] cnt;
    logic          rst_mode;
    logic          busy;

    assign rst_mode = det_on & ~freeze_mode;
    assign busy     = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sys_rst <= 1'b0;
            clk_run <= 1'b1;
        end else begin
            if (!rst_mode)      cnt <= '0;
            else if (below)     cnt <= LOAD;
            else if (busy)      cnt <= cnt - 1'b1;
            sys_rst <= rst_mode & (below | busy);
            clk_run <= ~(det_on & freeze_mode & below);
        end
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import sg_pkg::*;
#(
    parameter logic [7:0] REG_ADDR       = 8'hF5,
    parameter int         STRETCH_CYCLES = 655360,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_upper,
    input  logic       cmp_lower,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [1:0] clk_ctrl,
    output logic [1:0] clk_src,
    output logic       sys_rst,
    output logic       clk_run
);
    logic [N_CH-1:0] raw_cmp;
    logic [N_CH-1:0] syn_cmp;
    logic            s_up;
    logic            s_lo;
    logic            addr_hit;
    logic            wr_hit;
    sg_ctl_t         ctl;

    assign raw_cmp[CH_UPPER] = cmp_upper;
    assign raw_cmp[CH_LOWER] = cmp_lower;
    assign s_up = syn_cmp[CH_UPPER];
    assign s_lo = syn_cmp[CH_LOWER];

    assign addr_hit = (addr == REG_ADDR);
    assign wr_hit   = wr_en & addr_hit;

    sg_sync #(.N(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_cmp),
        .dout(syn_cmp)
    );

    sg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr_data(wr_data),
        .s_up   (s_up),
        .s_lo   (s_lo),
        .ctl    (ctl)
    );

    sg_resp #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .det_on     (~ctl.det_off),
        .freeze_mode(ctl.freeze),
        .below      (s_lo),
        .sys_rst    (sys_rst),
        .clk_run    (clk_run)
    );

    assign rd_data  = addr_hit ? sg_to_bus(ctl) : '0;
    assign clk_ctrl = ctl.clk_ctrl;
    assign clk_src  = ctl.clk_src;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
    parameter logic [7:0] REG_ADDR = 8'hF5
) (
    input logic       clk,
    input logic       rst,
    input logic       cmp_lower,
    input logic [7:0] addr,
    input logic       wr_en,
    input logic       s_lo,
    input logic       det_off,
    input logic       freeze_mode,
    input logic       flag_lo,
    input logic       sys_rst,
    input logic       clk_run
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(det_off) |-> (!sys_rst && clk_run)); // R10

    AST_FREEZE_NO_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(freeze_mode) |-> !sys_rst); // R9

    AST_RESET_MODE_CLOCK_RUNS: assert property (@(posedge clk) disable iff (rst)
        !$past(freeze_mode) |-> clk_run); // R7

    AST_RESET_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> $past(cmp_lower, 2)); // R11

    AST_LOW_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_lo) && !$past(det_off) && !$past(wr_en && addr == REG_ADDR))
        |-> flag_lo); // R4

    AST_LOW_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        (s_lo && !det_off) |=> flag_lo); // R6
endmodule

bind supply_guard sg_checker #(.REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_lower  (cmp_lower),
    .addr       (addr),
    .wr_en      (wr_en),
    .s_lo       (s_lo),
    .det_off    (ctl.det_off),
    .freeze_mode(ctl.freeze),
    .flag_lo    (ctl.flag_lo),
    .sys_rst    (sys_rst),
    .clk_run    (clk_run)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
    localparam logic [7:0] RA = 8'hF5;
    localparam int         ST = 20;
    localparam int         NV = 5;
    // {write address, write data, expected read at RA, expected clk_ctrl/clk_src}
    localparam logic [27:0] VEC [NV] = '{
        {8'hF5, 8'h0F, 8'h0F, 4'hF},
        {8'hF5, 8'hC6, 8'hC6, 4'h6},
        {8'h10, 8'h09, 8'hC6, 4'h6},
        {8'hF5, 8'h39, 8'h09, 4'h9},
        {8'hF5, 8'h00, 8'h00, 4'h0}
    };

    logic       clk = 0;
    logic       rst = 1;
    logic       cmp_upper = 0, cmp_lower = 0;
    logic [7:0] addr = RA, wr_data = 0;
    logic       wr_en = 0;
    logic [7:0] rd_data;
    logic [1:0] clk_ctrl, clk_src;
    logic       sys_rst, clk_run;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    supply_guard #(.REG_ADDR(RA), .STRETCH_CYCLES(ST)) u_supply_guard (
        .clk(clk), .rst(rst), .cmp_upper(cmp_upper), .cmp_lower(cmp_lower),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .clk_ctrl(clk_ctrl), .clk_src(clk_src), .sys_rst(sys_rst), .clk_run(clk_run)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0; addr = RA;
    endtask

    task automatic rd_chk(string req, logic [7:0] exp);
        addr = RA; #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        wait_n(3);
        rst = 0;
        // R1 reset state
        rd_chk("R1 reg", 8'h00);
        chk("R1 sys_rst", {7'b0, sys_rst}, 8'h00);
        chk("R1 clk_run", {7'b0, clk_run}, 8'h01);

        // R2 / R12 register vectors
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][27:20], VEC[i][19:12]);
            rd_chk("R2 R12 readback", VEC[i][11:4]);
            chk("R2 clk fields", {4'b0, clk_src, clk_ctrl}, {4'b0, VEC[i][3:0]});
            addr = 8'h10; #1;
            chk("R12 other read", rd_data, 8'h00);
            addr = RA;
        end

        // R3 upper flag tracks, read-only
        cmp_upper = 1;
        wait_n(2);
        rd_chk("R3 not yet", 8'h00);
        wait_n(1);
        rd_chk("R3 set", 8'h10);
        wr(RA, 8'h00);
        rd_chk("R3 write ignored", 8'h10);
        cmp_upper = 0;
        wait_n(3);
        rd_chk("R3 self clear", 8'h00);

        // R11 / R7 reset mode dip
        cmp_lower = 1;
        wait_n(2);
        chk("R11 no early reset", {7'b0, sys_rst}, 8'h00);
        wait_n(1);
        chk("R11 R7 reset asserted", {7'b0, sys_rst}, 8'h01);
        chk("R7 clk runs", {7'b0, clk_run}, 8'h01);
        rd_chk("R4 flag set", 8'h20);
        // R6 clear ignored while below
        wr(RA, 8'h00);
        rd_chk("R6 clear ignored", 8'h20);
        cmp_lower = 0;
        wait_n(2 + ST);
        chk("R7 stretch held", {7'b0, sys_rst}, 8'h01);
        wait_n(1);
        chk("R7 stretch end", {7'b0, sys_rst}, 8'h00);
        rd_chk("R4 sticky", 8'h20);
        // R5 write 1 keeps, write 0 clears
        wr(RA, 8'h20);
        rd_chk("R5 write one keeps", 8'h20);
        wr(RA, 8'h00);
        rd_chk("R5 cleared", 8'h00);

        // R8 redip restarts stretch
        cmp_lower = 1; wait_n(4);
        cmp_lower = 0; wait_n(8);
        cmp_lower = 1; wait_n(3);
        cmp_lower = 0;
        wait_n(2 + ST);
        chk("R8 restarted stretch held", {7'b0, sys_rst}, 8'h01);
        wait_n(1);
        chk("R8 restarted stretch end", {7'b0, sys_rst}, 8'h00);
        wr(RA, 8'h00);

        // R9 freeze mode
        wr(RA, 8'h40);
        cmp_lower = 1;
        wait_n(3);
        chk("R9 clock frozen", {7'b0, clk_run}, 8'h00);
        chk("R9 no reset", {7'b0, sys_rst}, 8'h00);
        cmp_lower = 0;
        wait_n(3);
        chk("R9 clock released", {7'b0, clk_run}, 8'h01);
        rd_chk("R9 R4 flag kept", 8'h60);
        wr(RA, 8'h40);
        rd_chk("R9 R5 cleared", 8'h40);
        wr(RA, 8'h00);

        // R10 disabled
        wr(RA, 8'h80);
        cmp_lower = 1; cmp_upper = 1;
        wait_n(4);
        rd_chk("R10 flags off", 8'h80);
        chk("R10 no reset", {7'b0, sys_rst}, 8'h00);
        chk("R10 clock runs", {7'b0, clk_run}, 8'h01);
        cmp_lower = 0; cmp_upper = 0;
        wait_n(3);
        wr(RA, 8'h00);
        // R10 disable during stretch
        cmp_lower = 1; wait_n(3);
        cmp_lower = 0; wait_n(5);
        chk("R10 stretch running", {7'b0, sys_rst}, 8'h01);
        wr(RA, 8'h80);
        wait_n(1);
        chk("R10 stretch cut", {7'b0, sys_rst}, 8'h00);
        rd_chk("R10 flag forced off", 8'h80);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule